// File: doc/BRIEF.md
# Dual ADC Channel Sequencer

This block sequences channel requests for two analog-to-digital converter units, each with four inputs. Unit 0 owns global channels 0 to 3 and unit 1 owns global channels 4 to 7. Each unit holds a two-bit channel code and a mode: single converts one channel, multi makes one pass over a range of channels, and scan repeats that range until software stops it. A unit can be started on its own through its configuration write. A 16-bit simultaneous-start register starts both units in the same cycle.

Each unit presents a request level and a global channel number to its converter. The request is held until the converter returns a one-cycle done pulse with a 10-bit result. The result is stored in a register for that channel. The next channel is requested only after that. A result bank can be read by channel number. The simultaneous-start bit reads back as set while the joint run is active and clears itself once both units have completed their channel sets.

Top module: `adc_pair_seq`

## Requirements
- R1: After reset, `sim_rdata` is 16'h0000, `unit_busy` is 0, no request is raised, and all result registers hold 0.
- R2: Mode code 2'b00 (single): the unit requests exactly one channel, base + code (base 0 for unit 0, 4 for unit 1). After the done pulse its busy flag clears.
- R3: Mode code 2'b01 (multi), or the unused code 2'b11: the unit requests channels base, base+1, up to base+code, once each, and then goes idle.
- R4: Unit 1 follows the same code mapping as unit 0, offset by four (global channels 4 to 7). The channel for unit u appears on `conv_ch[3u+2:3u]`.
- R5: A `sim_we` write with bit 15 set, made while both units are idle, sets `unit_busy` to 2'b11 and raises both requests in the cycle after the write. `sim_rdata[15]` reads 1 for as long as either unit is busy.
- R6: `sim_rdata[15]` clears by itself one cycle after both units are idle. In a joint run, a unit set to scan (2'b10) makes one pass only.
- R7: Within a unit, channels are requested in ascending order. The channel stays stable while the request is pending, and the next channel is requested only in the cycle after the done pulse is accepted.
- R8: Bits 14 to 0 of `sim_rdata` always read 0. A `sim_we` write with bit 15 clear starts nothing.
- R9: A configuration write to a unit that is busy, or made while `sim_rdata[15]` is set, is ignored. Code, mode and start/stop all keep their values.
- R10: Mode 2'b10 (scan), started on its own: after the last channel in the range, the unit wraps to base and keeps going. A configuration write with `cfg_start` = 0 stops it, and busy clears in the next cycle.
- R11: Each accepted done pulse stores `conv_data` for that unit in the result register of the requested channel. `rd_data` shows the register selected by `rd_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 2 | Per-unit configuration write strobe |
| cfg_code | input | 2 | Channel code for the configuration write |
| cfg_mode | input | 2 | Mode: 00 single, 01 multi, 10 scan, 11 as multi |
| cfg_start | input | 1 | 1 starts an idle unit, 0 stops a running one |
| sim_we | input | 1 | Write strobe for the simultaneous-start register |
| sim_wdata | input | 16 | Write data, only bit 15 is used |
| sim_rdata | output | 16 | Register readback, bit 15 = joint run active |
| unit_busy | output | 2 | Per-unit running flag |
| conv_req | output | 2 | Per-unit conversion request level |
| conv_ch | output | 6 | Requested global channel, 3 bits per unit |
| conv_done | input | 2 | Per-unit one-cycle done pulse |
| conv_data | input | 20 | Per-unit 10-bit result, unit 1 in the upper half |
| rd_sel | input | 3 | Result register select |
| rd_data | output | 10 | Selected result register |

## Verification
The assertions check, on every cycle, that a pending channel holds until its done pulse and then steps up by one. They also check that the channel never leaves the configured range, that the configuration stays frozen while a unit runs, and that a non-wrapping run ends at its last channel. On the shared bit they check that it stays set while either unit is busy and falls only after both are idle. The bench scenarios are needed for the rest: the whole order of channels for each mode and code, the offset mapping of the second unit, scan wrap-around and stop, ignored writes during a run, and the values stored in the result bank.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int UNIT_CH = 4;
  localparam int CODE_W  = $clog2(UNIT_CH);

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_MULTI  = 2'b01,
    MODE_SCAN   = 2'b10,
    MODE_RSVD   = 2'b11
  } seq_mode_e;

  // first channel offset of a run: the code itself in single mode, else 0
  function automatic logic [CODE_W-1:0] seq_first(seq_mode_e mode, logic [CODE_W-1:0] code);
    return (mode == MODE_SINGLE) ? code : '0;
  endfunction

  // a self-started scan wraps; a joint run never wraps
  function automatic logic seq_wraps(seq_mode_e mode, logic joint);
    return (mode == MODE_SCAN) && !joint;
  endfunction
endpackage

// File: rtl/adc_unit_seq.sv
module adc_unit_seq
  import adc_seq_pkg::*;
#(
  parameter int BASE   = 0,
  parameter int CH_W   = 3,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_start,
  input  logic              hold,
  input  logic              launch_joint,
  output logic              run,
  output logic [CH_W-1:0]   ch,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  output logic              wr_en,
  output logic [CH_W-1:0]   wr_ch,
  output logic [DATA_W-1:0] wr_data
);
  logic [CODE_W-1:0] code_q, cur_q, first_q, last_q;
  seq_mode_e         mode_q;
  logic              run_q, wrap_q;

  logic              cfg_ok, self_go, go, stop, accept, at_last;
  logic [CODE_W-1:0] code_eff;
  seq_mode_e         mode_eff;

  assign cfg_ok   = cfg_we && !run_q && !hold;
  assign code_eff = cfg_ok ? cfg_code : code_q;
  assign mode_eff = cfg_ok ? seq_mode_e'(cfg_mode) : mode_q;
  assign self_go  = cfg_ok && cfg_start;
  assign go       = self_go || launch_joint;
  assign stop     = cfg_we && !cfg_start && run_q && !hold;
  assign accept   = run_q && done;
  assign at_last  = (cur_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      mode_q  <= MODE_SINGLE;
      run_q   <= 1'b0;
      wrap_q  <= 1'b0;
      cur_q   <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      if (cfg_ok) begin
        code_q <= cfg_code;
        mode_q <= seq_mode_e'(cfg_mode);
      end
      if (go) begin
        run_q   <= 1'b1;
        first_q <= seq_first(mode_eff, code_eff);
        cur_q   <= seq_first(mode_eff, code_eff);
        last_q  <= code_eff;
        wrap_q  <= seq_wraps(mode_eff, launch_joint);
      end else if (stop) begin
        run_q <= 1'b0;
      end else if (accept) begin
        if (!at_last)    cur_q <= cur_q + 1'b1;
        else if (wrap_q) cur_q <= first_q;
        else             run_q <= 1'b0;
      end
    end
  end

  assign run     = run_q;
  assign ch      = CH_W'(BASE) + CH_W'(cur_q);
  assign wr_en   = accept;
  assign wr_ch   = ch;
  assign wr_data = data;

  assert_ch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !done && !stop |=> run_q && $stable(ch));
  assert_ascend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && done && !at_last && !stop |=> ch == $past(ch) + CH_W'(1));
  assert_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cur_q >= first_q) && (cur_q <= last_q));
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(code_q) && $stable(mode_q));
  assert_run_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && done && at_last && !wrap_q |=> !run_q);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int N_UNITS = 2,
  parameter int N_CH    = 8,
  parameter int CH_W    = 3,
  parameter int DATA_W  = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_UNITS-1:0]        wr_en,
  input  logic [N_UNITS*CH_W-1:0]   wr_ch,
  input  logic [N_UNITS*DATA_W-1:0] wr_data,
  input  logic [CH_W-1:0]           rd_sel,
  output logic [DATA_W-1:0]         rd_data
);
  logic [DATA_W-1:0] res_q [N_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_CH; i++) res_q[i] <= '0;
    end else begin
      for (int u = 0; u < N_UNITS; u++)
        if (wr_en[u]) res_q[wr_ch[u*CH_W +: CH_W]] <= wr_data[u*DATA_W +: DATA_W];
    end
  end

  assign rd_data = res_q[rd_sel];
endmodule

// File: rtl/adc_pair_seq.sv
module adc_pair_seq
  import adc_seq_pkg::*;
#(
  parameter int N_UNITS = 2,
  parameter int DATA_W  = 10,
  parameter int REG_W   = 16,
  parameter int SIM_BIT = 15,
  localparam int N_CH   = N_UNITS * UNIT_CH,
  localparam int CH_W   = $clog2(N_CH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_UNITS-1:0]        cfg_we,
  input  logic [CODE_W-1:0]         cfg_code,
  input  logic [1:0]                cfg_mode,
  input  logic                      cfg_start,
  input  logic                      sim_we,
  input  logic [REG_W-1:0]          sim_wdata,
  output logic [REG_W-1:0]          sim_rdata,
  output logic [N_UNITS-1:0]        unit_busy,
  output logic [N_UNITS-1:0]        conv_req,
  output logic [N_UNITS*CH_W-1:0]   conv_ch,
  input  logic [N_UNITS-1:0]        conv_done,
  input  logic [N_UNITS*DATA_W-1:0] conv_data,
  input  logic [CH_W-1:0]           rd_sel,
  output logic [DATA_W-1:0]         rd_data
);
  logic                      sim_q, joint_launch, any_run;
  logic [N_UNITS-1:0]        run, wr_en;
  logic [N_UNITS*CH_W-1:0]   wr_ch;
  logic [N_UNITS*DATA_W-1:0] wr_data;
  logic                      unused_wbits;

  assign any_run      = |run;
  assign joint_launch = sim_we && sim_wdata[SIM_BIT] && !sim_q && !any_run;
  assign unused_wbits = ^{sim_wdata[REG_W-1:SIM_BIT+1], sim_wdata[SIM_BIT-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n)               sim_q <= 1'b0;
    else if (joint_launch)    sim_q <= 1'b1;
    else if (sim_q && !any_run) sim_q <= 1'b0;
  end

  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    adc_unit_seq #(.BASE(u * UNIT_CH), .CH_W(CH_W), .DATA_W(DATA_W)) i_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we[u]),
      .cfg_code     (cfg_code),
      .cfg_mode     (cfg_mode),
      .cfg_start    (cfg_start),
      .hold         (sim_q),
      .launch_joint (joint_launch),
      .run          (run[u]),
      .ch           (conv_ch[u*CH_W +: CH_W]),
      .done         (conv_done[u]),
      .data         (conv_data[u*DATA_W +: DATA_W]),
      .wr_en        (wr_en[u]),
      .wr_ch        (wr_ch[u*CH_W +: CH_W]),
      .wr_data      (wr_data[u*DATA_W +: DATA_W])
    );
  end

  adc_result_bank #(.N_UNITS(N_UNITS), .N_CH(N_CH), .CH_W(CH_W), .DATA_W(DATA_W)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ch   (wr_ch),
    .wr_data (wr_data),
    .rd_sel  (rd_sel),
    .rd_data (rd_data)
  );

  always_comb begin
    sim_rdata          = '0;
    sim_rdata[SIM_BIT] = sim_q;
  end
  assign unit_busy = run;
  assign conv_req  = run;

  assert_sim_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sim_q && any_run |=> sim_q);
  assert_sim_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sim_q) |-> &run);
  assert_sim_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sim_q) |-> $past(!any_run));
endmodule

// File: tb/test_adc_pair_seq.sv
module test_adc_pair_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_we = '0;
  logic [1:0]  cfg_code = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_start = 1'b0;
  logic        sim_we = 1'b0;
  logic [15:0] sim_wdata = '0;
  logic [15:0] sim_rdata;
  logic [1:0]  unit_busy, conv_req, conv_done;
  logic [5:0]  conv_ch;
  logic [9:0]  dat [2];
  logic [19:0] conv_data;
  logic [2:0]  rd_sel = '0;
  logic [9:0]  rd_data;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [2:0] log_ch [2][64];
  int         n_log [2];
  logic [9:0] exp_res [8];

  assign conv_data = {dat[1], dat[0]};
  always #10 clk = ~clk;

  adc_pair_seq i_adc_pair_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_mode(cfg_mode),
    .cfg_start(cfg_start), .sim_we(sim_we), .sim_wdata(sim_wdata), .sim_rdata(sim_rdata),
    .unit_busy(unit_busy), .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .rd_sel(rd_sel), .rd_data(rd_data));

  // unit, mode, code
  localparam logic [4:0] VEC [8] = '{
    {1'b0, 2'b00, 2'd0}, {1'b0, 2'b00, 2'd3}, {1'b1, 2'b00, 2'd1}, {1'b0, 2'b01, 2'd0},
    {1'b0, 2'b01, 2'd2}, {1'b1, 2'b01, 2'd3}, {1'b1, 2'b00, 2'd3}, {1'b0, 2'b11, 2'd1}};

  task automatic chk(bit ok, string rq, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic agent(int u, int lat);
    int c = 0;
    logic [4:0] stamp = '0;
    forever begin
      @(negedge clk);
      conv_done[u] = 1'b0;
      if (conv_req[u]) begin
        c++;
        if (c == lat) begin
          stamp++;
          dat[u] = {(u == 1) ? 2'b11 : 2'b01, stamp, conv_ch[u*3 +: 3]};
          exp_res[conv_ch[u*3 +: 3]] = dat[u];
          log_ch[u][n_log[u]] = conv_ch[u*3 +: 3];
          if (n_log[u] < 63) n_log[u]++;
          conv_done[u] = 1'b1;
          c = 0;
        end
      end else c = 0;
    end
  endtask

  task automatic wr_cfg(int u, logic [1:0] code, logic [1:0] mode, logic st);
    @(negedge clk);
    cfg_we = '0; cfg_we[u] = 1'b1; cfg_code = code; cfg_mode = mode; cfg_start = st;
    @(negedge clk);
    cfg_we = '0;
  endtask

  task automatic wr_sim(logic [15:0] d);
    @(negedge clk);
    sim_we = 1'b1; sim_wdata = d;
    @(negedge clk);
    sim_we = 1'b0;
  endtask

  task automatic wait_idle(int u);
    for (int k = 0; k < 400 && unit_busy[u]; k++) @(negedge clk);
  endtask

  task automatic chk_seq(int u, int lo, int hi, int n, string rq);
    bit ok = (n_log[u] == n);
    int bad_a = n_log[u], bad_e = n;
    for (int i = 0; i < n && ok; i++)
      if (int'(log_ch[u][i]) != lo + i % (hi - lo + 1)) begin
        ok = 1'b0; bad_a = int'(log_ch[u][i]); bad_e = lo + i % (hi - lo + 1);
      end
    chk(ok, rq, bad_a, bad_e);
  endtask

  task automatic clr_logs();
    n_log[0] = 0; n_log[1] = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    conv_done = '0; dat[0] = '0; dat[1] = '0;
    for (int i = 0; i < 8; i++) exp_res[i] = '0;
    clr_logs();
    fork agent(0, 3); agent(1, 5); join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sim_rdata == 16'h0000, "R1", int'(sim_rdata), 0);
    chk(unit_busy == 2'b00 && conv_req == 2'b00, "R1", int'({unit_busy, conv_req}), 0);
    rd_sel = 3'd5; #1;
    chk(rd_data == 10'd0, "R1", int'(rd_data), 0);

    // vector walk: R2 single, R3 multi, R4 upper unit, R11 results
    for (int v = 0; v < 8; v++) begin
      int u = int'(VEC[v][4]);
      int m = int'(VEC[v][3:2]);
      int c = int'(VEC[v][1:0]);
      int lo = u * 4 + ((m == 0) ? c : 0);
      int hi = u * 4 + c;
      clr_logs();
      wr_cfg(u, 2'(c), 2'(m), 1'b1);
      wait_idle(u);
      chk_seq(u, lo, hi, hi - lo + 1, (u == 1) ? "R4" : ((m == 0) ? "R2" : "R3"));
      chk(unit_busy == 2'b00, "R2", int'(unit_busy), 0);
      rd_sel = 3'(hi); #1;
      chk(rd_data == exp_res[hi], "R11", int'(rd_data), int'(exp_res[hi]));
    end

    // R8 write without bit 15
    wr_sim(16'h7FFF);
    chk(unit_busy == 2'b00 && sim_rdata == 16'h0000, "R8", int'(sim_rdata), 0);

    // R5/R6 joint run: unit0 multi 3, unit1 single 2
    wr_cfg(0, 2'd3, 2'b01, 1'b0);
    wr_cfg(1, 2'd2, 2'b00, 1'b0);
    clr_logs();
    wr_sim(16'h8000);
    chk(sim_rdata == 16'h8000 && unit_busy == 2'b11, "R5", int'({sim_rdata[15], unit_busy}), 7);
    begin
      bit ok = 1'b1, saw_one = 1'b0;
      for (int k = 0; k < 400 && sim_rdata[15]; k++) begin
        if (unit_busy != 2'b00 && sim_rdata != 16'h8000) ok = 1'b0;
        if (unit_busy == 2'b01) saw_one = 1'b1;
        @(negedge clk);
      end
      chk(ok && saw_one, "R5", int'({ok, saw_one}), 3);
    end
    chk(sim_rdata == 16'h0000 && unit_busy == 2'b00, "R6", int'(sim_rdata), 0);
    chk_seq(0, 0, 3, 4, "R6");
    chk_seq(1, 6, 6, 1, "R6");

    // R9 ignored reconfig while busy
    clr_logs();
    wr_cfg(0, 2'd1, 2'b01, 1'b1);
    wr_cfg(0, 2'd3, 2'b00, 1'b1);
    wait_idle(0);
    chk_seq(0, 0, 1, 2, "R9");
    clr_logs();
    wr_cfg(1, 2'd1, 2'b10, 1'b0);
    wr_sim(16'h8000);
    wr_cfg(1, 2'd0, 2'b00, 1'b0);
    for (int k = 0; k < 400 && sim_rdata[15]; k++) @(negedge clk);
    chk_seq(0, 0, 1, 2, "R9");
    // R6 scan makes one pass in a joint run
    chk_seq(1, 4, 5, 2, "R6");

    // R10 self-started scan wraps until stopped
    clr_logs();
    wr_cfg(1, 2'd1, 2'b10, 1'b1);
    for (int k = 0; k < 400 && n_log[1] < 5; k++) @(negedge clk);
    wr_cfg(1, 2'd0, 2'b00, 1'b0);
    chk(unit_busy == 2'b00, "R10", int'(unit_busy), 0);
    chk_seq(1, 4, 5, 5, "R10");
    rd_sel = 3'd4; #1;
    chk(rd_data == exp_res[4], "R11", int'(rd_data), int'(exp_res[4]));
    // R8 unused bits read zero
    chk(sim_rdata[14:0] == 15'd0, "R8", int'(sim_rdata), 0);
    summary();
  end
endmodule